// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Arbiter

This block keeps the receive and transmit interrupt state for a pair of serial channels, A (index 0) and B (index 1). For each channel it holds a receive-pending flag, a transmit-pending flag and one "under service" flag for each of them. From these flags it builds three results:

- a single active-high interrupt line;
- a byte of pending bits;
- a vector byte whose code depends on the channel, the cause and a status-high/low select.

Receive takes precedence over transmit through the under-service flags. A transmit interrupt raised while the same channel's receive is still under service stays latent. It surfaces when the receive side is released.

Events reach the block one per clock on a single port, as a 3-bit event code plus a channel select. The enable fields of the configuration registers arrive as plain level inputs. Software reads the pending byte or the vector byte through a one-bit register select.

Top module: `dual_serial_irq_arb`

## Requirements
- R1: After reset the interrupt line is 0, the pending byte is 0x00 and the vector byte is 0x06.
- R2: Event code 1 (character received) on channel c sets c's receive-pending and receive-under-service flags and its receive pending bit. It loads the receive vector of c.
- R3: Event code 2 (transmit buffer written) on channel c leaves c's transmit-pending flag set. If c's receive is not under service, it also sets transmit-under-service, sets c's transmit pending bit when c's transmit enable is 1, and loads the transmit vector of c. Otherwise the pending byte and the vector byte are unchanged.
- R4: Event code 5 (clear under-service) on channel c behaves as follows. If receive is under service, it releases it, and when transmit is still pending it raises transmit as in R3. Otherwise it releases transmit-under-service. No other result changes in either case.
- R5: Event code 4 (clear transmit) on channel c clears c's transmit-pending and transmit-under-service flags and its transmit pending bit, and loads the no-interrupt vector. If c's receive is still pending, it then raises receive again as in R2.
- R6: Event code 3 (data register read) on channel c clears c's receive-pending and receive-under-service flags and its receive pending bit, and loads the no-interrupt vector. If c's transmit is still pending, it then raises transmit as in R3.
- R7: Vector codes with statusHigh=0 are:
  - none 0x06
  - receive A 0x0C
  - receive B 0x04
  - transmit A 0x08
  - transmit B 0x00

  With statusHigh=1 they are:
  - none 0x60
  - receive A 0x30
  - receive B 0x20
  - transmit A 0x10
  - transmit B 0x00

  The select is sampled on the edge that loads the vector.
- R8: Pending byte layout:
  - bit 5: receive A
  - bit 4: transmit A
  - bit 2: receive B
  - bit 1: transmit B

  Bits 7, 6, 3 and 0 read 0.
- R9: At each clock edge the interrupt line takes the OR over both channels of three terms:
  - (transmit enable AND transmit-pending);
  - (receive mode equal to 01 or 10 AND receive-pending);
  - (break enable AND break status).

  The flags used are those that result from the edge's event. The enables are the values present at that edge.
- R10: With break enable and break status both 1 on a channel and no other source active, the interrupt line is 1 one edge later. It returns to 0 one edge after either input falls.
- R11: With rdSel=0, rdData shows the pending byte. With rdSel=1 it shows the vector byte. The selection is combinational.
- R12: Event codes 0, 6 and 7 change no flag, pending bit or vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evKind | input | 3 | Event code (1 rx char, 2 tx write, 3 data read, 4 clear tx, 5 clear under-service) |
| evChan | input | 1 | Channel of the event, 0 = A, 1 = B |
| statusHigh | input | 1 | Vector code set select |
| txIntEn | input | 2 | Transmit interrupt enable per channel |
| rxIntMode | input | 4 | Receive interrupt mode, 2 bits per channel (channel B in [3:2]) |
| brkIntEn | input | 2 | Break interrupt enable per channel |
| brkStatus | input | 2 | Break status per channel |
| rdSel | input | 1 | 0 reads the pending byte, 1 reads the vector byte |
| rdData | output | 8 | Selected register byte |
| irq | output | 1 | Registered active-high interrupt |

## Verification
An event presented before a rising edge produces all of its results on that edge: the pending byte, the vector byte and the interrupt line. A change to an enable or to a break input alone shows on the interrupt line at the next edge. The read mux adds no delay. The bench therefore drives each event and each configuration on a falling edge, lets exactly one rising edge pass, and compares everything at the next falling edge. It also steps the read select with a short settle delay inside that low phase. The expected values come from a behavioural model in the bench that applies the event rules to its own copy of the flags.

// File: rtl/dual_irq_pkg.sv
package dual_irq_pkg;
  localparam int NUM_CHAN = 2;
  localparam int BYTE_W   = 8;
  localparam int MODE_W   = 2;

  typedef enum logic [2:0] {
    EV_NONE      = 3'd0,
    EV_RX_CHAR   = 3'd1,
    EV_TX_WRITE  = 3'd2,
    EV_DATA_READ = 3'd3,
    EV_CLR_TX    = 3'd4,
    EV_CLR_IUS   = 3'd5
  } evKind_e;

  typedef enum logic [1:0] {
    VK_NONE = 2'd0,
    VK_RX   = 2'd1,
    VK_TX   = 2'd2
  } vecKind_e;

  // strobes from control to datapath, all for channel 'chan'
  typedef struct packed {
    logic     chan;
    logic     setRxPend;
    logic     clrRxPend;
    logic     setRxSvc;
    logic     clrRxSvc;
    logic     setTxPend;
    logic     clrTxPend;
    logic     setTxSvc;
    logic     clrTxSvc;
    logic     bitRxSet;
    logic     bitRxClr;
    logic     bitTxSet;
    logic     bitTxClr;
    logic     vecLoad;
    vecKind_e vecKind;
  } strobes_t;

  function automatic logic [BYTE_W-1:0] vecCode(vecKind_e kind, logic chan, logic hi);
    logic [BYTE_W-1:0] code;
    case (kind)
      VK_RX:   code = chan ? (hi ? 8'h20 : 8'h04) : (hi ? 8'h30 : 8'h0C);
      VK_TX:   code = chan ? 8'h00 : (hi ? 8'h10 : 8'h08);
      default: code = hi ? 8'h60 : 8'h06;
    endcase
    return code;
  endfunction
endpackage

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import dual_irq_pkg::*;
(
  input  logic [2:0]          evKind,
  input  logic                evChan,
  input  logic [NUM_CHAN-1:0] rxPend,
  input  logic [NUM_CHAN-1:0] rxSvc,
  input  logic [NUM_CHAN-1:0] txPend,
  input  logic [NUM_CHAN-1:0] txSvc,
  input  logic [NUM_CHAN-1:0] txIntEn,
  output strobes_t            strb
);
  logic curRxPend, curRxSvc, curTxPend, curTxSvc, curTxEn;

  always_comb begin
    curRxPend = rxPend[evChan];
    curRxSvc  = rxSvc[evChan];
    curTxPend = txPend[evChan];
    curTxSvc  = txSvc[evChan];
    curTxEn   = txIntEn[evChan];

    strb         = '0;
    strb.chan    = evChan;
    strb.vecKind = VK_NONE;

    case (evKind_e'(evKind))
      EV_RX_CHAR: begin
        strb.setRxPend = 1'b1;
        strb.setRxSvc  = 1'b1;
        strb.bitRxSet  = 1'b1;
        strb.vecLoad   = 1'b1;
        strb.vecKind   = VK_RX;
      end
      EV_TX_WRITE: begin
        strb.setTxPend = 1'b1;
        if (!curRxSvc) begin
          strb.setTxSvc = 1'b1;
          strb.bitTxSet = curTxEn;
          strb.vecLoad  = 1'b1;
          strb.vecKind  = VK_TX;
        end
      end
      EV_DATA_READ: begin
        strb.clrRxPend = 1'b1;
        strb.clrRxSvc  = 1'b1;
        strb.bitRxClr  = 1'b1;
        strb.vecLoad   = 1'b1;
        strb.vecKind   = VK_NONE;
        if (curTxPend) begin
          strb.setTxSvc = 1'b1;
          strb.bitTxSet = curTxEn;
          strb.vecKind  = VK_TX;
        end
      end
      EV_CLR_TX: begin
        strb.clrTxPend = 1'b1;
        strb.clrTxSvc  = 1'b1;
        strb.bitTxClr  = 1'b1;
        strb.vecLoad   = 1'b1;
        strb.vecKind   = VK_NONE;
        if (curRxPend) begin
          strb.setRxSvc = 1'b1;
          strb.bitRxSet = 1'b1;
          strb.vecKind  = VK_RX;
        end
      end
      EV_CLR_IUS: begin
        if (curRxSvc) begin
          strb.clrRxSvc = 1'b1;
          if (curTxPend) begin
            strb.setTxSvc = 1'b1;
            strb.bitTxSet = curTxEn;
            strb.vecLoad  = 1'b1;
            strb.vecKind  = VK_TX;
          end
        end else if (curTxSvc) begin
          strb.clrTxSvc = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_arb_dp.sv
module irq_arb_dp
  import dual_irq_pkg::*;
#(
  parameter logic [BYTE_W-1:0] VEC_RESET = 8'h06
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobes_t                   strb,
  input  logic                       statusHigh,
  input  logic [NUM_CHAN-1:0]        txIntEn,
  input  logic [NUM_CHAN*MODE_W-1:0] rxIntMode,
  input  logic [NUM_CHAN-1:0]        brkIntEn,
  input  logic [NUM_CHAN-1:0]        brkStatus,
  output logic [NUM_CHAN-1:0]        rxPend,
  output logic [NUM_CHAN-1:0]        rxSvc,
  output logic [NUM_CHAN-1:0]        txPend,
  output logic [NUM_CHAN-1:0]        txSvc,
  output logic [BYTE_W-1:0]          pendingByte,
  output logic [BYTE_W-1:0]          vectorByte,
  output logic                       irq
);
  logic [NUM_CHAN-1:0] rxPendN, rxSvcN, txPendN, txSvcN;
  logic [NUM_CHAN-1:0] bitRx, bitTx, bitRxN, bitTxN;
  logic [NUM_CHAN-1:0] srcTerm;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic hit;
    logic rxModeOn;
    logic [MODE_W-1:0] mode;
    assign hit      = (strb.chan == c[0]);
    assign mode     = rxIntMode[c*MODE_W +: MODE_W];
    assign rxModeOn = (mode == 2'b01) || (mode == 2'b10);

    assign rxPendN[c] = (hit && strb.setRxPend) ? 1'b1 : (hit && strb.clrRxPend) ? 1'b0 : rxPend[c];
    assign rxSvcN[c]  = (hit && strb.setRxSvc)  ? 1'b1 : (hit && strb.clrRxSvc)  ? 1'b0 : rxSvc[c];
    assign txPendN[c] = (hit && strb.setTxPend) ? 1'b1 : (hit && strb.clrTxPend) ? 1'b0 : txPend[c];
    assign txSvcN[c]  = (hit && strb.setTxSvc)  ? 1'b1 : (hit && strb.clrTxSvc)  ? 1'b0 : txSvc[c];
    assign bitRxN[c]  = (hit && strb.bitRxSet)  ? 1'b1 : (hit && strb.bitRxClr)  ? 1'b0 : bitRx[c];
    assign bitTxN[c]  = (hit && strb.bitTxSet)  ? 1'b1 : (hit && strb.bitTxClr)  ? 1'b0 : bitTx[c];

    assign srcTerm[c] = (txIntEn[c] && txPendN[c]) ||
                        (rxModeOn && rxPendN[c]) ||
                        (brkIntEn[c] && brkStatus[c]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPend     <= '0;
      rxSvc      <= '0;
      txPend     <= '0;
      txSvc      <= '0;
      bitRx      <= '0;
      bitTx      <= '0;
      vectorByte <= VEC_RESET;
      irq        <= 1'b0;
    end else begin
      rxPend <= rxPendN;
      rxSvc  <= rxSvcN;
      txPend <= txPendN;
      txSvc  <= txSvcN;
      bitRx  <= bitRxN;
      bitTx  <= bitTxN;
      if (strb.vecLoad) vectorByte <= vecCode(strb.vecKind, strb.chan, statusHigh);
      irq <= |srcTerm;
    end
  end

  // channel A occupies the upper half, channel B the lower half
  assign pendingByte = {2'b00, bitRx[0], bitTx[0], 1'b0, bitRx[1], bitTx[1], 1'b0};
endmodule

// File: rtl/dual_serial_irq_arb.sv
module dual_serial_irq_arb
  import dual_irq_pkg::*;
#(
  parameter logic [BYTE_W-1:0] VEC_RESET = 8'h06
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  evKind,
  input  logic        evChan,
  input  logic        statusHigh,
  input  logic [1:0]  txIntEn,
  input  logic [3:0]  rxIntMode,
  input  logic [1:0]  brkIntEn,
  input  logic [1:0]  brkStatus,
  input  logic        rdSel,
  output logic [7:0]  rdData,
  output logic        irq
);
  strobes_t            strb;
  logic [NUM_CHAN-1:0] rxPend, rxSvc, txPend, txSvc;
  logic [BYTE_W-1:0]   pendingByte, vectorByte;

  irq_arb_ctrl u_ctrl (
    .evKind  (evKind),
    .evChan  (evChan),
    .rxPend  (rxPend),
    .rxSvc   (rxSvc),
    .txPend  (txPend),
    .txSvc   (txSvc),
    .txIntEn (txIntEn),
    .strb    (strb)
  );

  irq_arb_dp #(.VEC_RESET(VEC_RESET)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .statusHigh  (statusHigh),
    .txIntEn     (txIntEn),
    .rxIntMode   (rxIntMode),
    .brkIntEn    (brkIntEn),
    .brkStatus   (brkStatus),
    .rxPend      (rxPend),
    .rxSvc       (rxSvc),
    .txPend      (txPend),
    .txSvc       (txSvc),
    .pendingByte (pendingByte),
    .vectorByte  (vectorByte),
    .irq         (irq)
  );

  assign rdData = rdSel ? vectorByte : pendingByte;
endmodule

// File: rtl/dual_serial_irq_arb_chk.sv
module dual_serial_irq_arb_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] evKind,
  input logic       evChan,
  input logic       statusHigh,
  input logic [1:0] txIntEn,
  input logic [3:0] rxIntMode,
  input logic [1:0] brkIntEn,
  input logic [1:0] brkStatus,
  input logic [7:0] pendingByte,
  input logic [7:0] vectorByte,
  input logic       irq
);
  logic rxOffA, rxOffB;
  assign rxOffA = (rxIntMode[1:0] == 2'b00) || (rxIntMode[1:0] == 2'b11);
  assign rxOffB = (rxIntMode[3:2] == 2'b00) || (rxIntMode[3:2] == 2'b11);

  assert_rx_sets_bit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evKind == 3'd1 && evChan == 1'b0) |=> pendingByte[5]);

  assert_rx_b_vector_R7: assert property (@(posedge clk) disable iff (!rstN)
    (evKind == 3'd1 && evChan == 1'b1 && !statusHigh) |=> (vectorByte == 8'h04));

  assert_clr_tx_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (evKind == 3'd4 && evChan == 1'b0) |=> !pendingByte[4]);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evKind == 3'd3 && evChan == 1'b1) |=> !pendingByte[2]);

  assert_quiet_line_R9: assert property (@(posedge clk) disable iff (!rstN)
    (txIntEn == 2'b00 && brkIntEn == 2'b00 && rxOffA && rxOffB) |=> !irq);

  assert_break_raises_R10: assert property (@(posedge clk) disable iff (!rstN)
    (brkIntEn[0] && brkStatus[0]) |=> irq);
endmodule

bind dual_serial_irq_arb dual_serial_irq_arb_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .evKind      (evKind),
  .evChan      (evChan),
  .statusHigh  (statusHigh),
  .txIntEn     (txIntEn),
  .rxIntMode   (rxIntMode),
  .brkIntEn    (brkIntEn),
  .brkStatus   (brkStatus),
  .pendingByte (pendingByte),
  .vectorByte  (vectorByte),
  .irq         (irq)
);

// File: tb/dual_serial_irq_arb_tb.sv
`timescale 1ns/1ps
module dual_serial_irq_arb_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] evKind = 3'd0;
  logic       evChan = 1'b0;
  logic       statusHigh = 1'b0;
  logic [1:0] txIntEn = 2'b00;
  logic [3:0] rxIntMode = 4'b0000;
  logic [1:0] brkIntEn = 2'b00;
  logic [1:0] brkStatus = 2'b00;
  logic       rdSel = 1'b0;
  logic [7:0] rdData;
  logic       irq;

  always #2.5 clk = ~clk;

  dual_serial_irq_arb u_dut (
    .clk(clk), .rstN(rstN), .evKind(evKind), .evChan(evChan),
    .statusHigh(statusHigh), .txIntEn(txIntEn), .rxIntMode(rxIntMode),
    .brkIntEn(brkIntEn), .brkStatus(brkStatus), .rdSel(rdSel),
    .rdData(rdData), .irq(irq)
  );

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  // model state, index 0 = A, 1 = B
  bit mRxP[2], mRxS[2], mTxP[2], mTxS[2], mBRx[2], mBTx[2];
  logic [7:0] mVec;

  function automatic logic [7:0] expCode(int kind, int ch, bit hi);
    if (kind == 1) return ch == 0 ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
    if (kind == 2) return ch == 0 ? (hi ? 8'h10 : 8'h08) : 8'h00;
    return hi ? 8'h60 : 8'h06;
  endfunction

  function automatic logic [7:0] expPending();
    return {2'b00, mBRx[0], mBTx[0], 1'b0, mBRx[1], mBTx[1], 1'b0};
  endfunction

  function automatic bit expIrq();
    bit r = 0;
    for (int c = 0; c < 2; c++) begin
      logic [1:0] md = rxIntMode[2*c +: 2];
      r |= (txIntEn[c] && mTxP[c]) || ((md == 2'b01 || md == 2'b10) && mRxP[c]) ||
           (brkIntEn[c] && brkStatus[c]);
    end
    return r;
  endfunction

  task automatic mSetRx(int ch);
    mRxP[ch] = 1; mRxS[ch] = 1; mBRx[ch] = 1; mVec = expCode(1, ch, statusHigh);
  endtask

  task automatic mSetTx(int ch);
    mTxP[ch] = 1;
    if (!mRxS[ch]) begin
      mTxS[ch] = 1;
      if (txIntEn[ch]) mBTx[ch] = 1;
      mVec = expCode(2, ch, statusHigh);
    end
  endtask

  task automatic mApply(int kind, int ch);
    case (kind)
      1: mSetRx(ch);
      2: begin mTxP[ch] = 0; mSetTx(ch); end
      3: begin
        mRxP[ch] = 0; mRxS[ch] = 0; mBRx[ch] = 0; mVec = expCode(0, ch, statusHigh);
        if (mTxP[ch]) mSetTx(ch);
      end
      4: begin
        mTxP[ch] = 0; mTxS[ch] = 0; mBTx[ch] = 0; mVec = expCode(0, ch, statusHigh);
        if (mRxP[ch]) mSetRx(ch);
      end
      5: begin
        if (mRxS[ch]) begin
          mRxS[ch] = 0;
          if (mTxP[ch]) mSetTx(ch);
        end else if (mTxS[ch]) mTxS[ch] = 0;
      end
      default: ;
    endcase
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  // called in the low phase; checks every output against the model
  task automatic checkAll(string req);
    rdSel = 1'b0; #0.5;
    check({req, " pending R8 R11"}, rdData, expPending());
    rdSel = 1'b1; #0.5;
    check({req, " vector R7 R11"}, rdData, mVec);
    check({req, " irq R9"}, {7'd0, irq}, {7'd0, expIrq()});
  endtask

  // starts and ends at a falling edge
  task automatic doEv(int kind, int ch, string req);
    evKind = 3'(kind); evChan = 1'(ch);
    @(posedge clk);
    mApply(kind, ch);
    @(negedge clk);
    evKind = 3'd0;
    checkAll(req);
  endtask

  task automatic idle(string req);
    @(posedge clk);
    @(negedge clk);
    checkAll(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int c = 0; c < 2; c++) begin
      mRxP[c] = 0; mRxS[c] = 0; mTxP[c] = 0; mTxS[c] = 0; mBRx[c] = 0; mBTx[c] = 0;
    end
    mVec = 8'h06;
    repeat (3) @(negedge clk);
    checkAll("R1 reset");
    rstN = 1'b1;
    @(negedge clk);

    // directed: receive-over-transmit priority on channel A
    txIntEn = 2'b11; rxIntMode = 4'b1001;
    idle("R9 enables");
    doEv(1, 0, "R2 rx A");
    doEv(2, 0, "R3 tx A under rx service");
    doEv(5, 0, "R4 clear service re-raises tx");
    doEv(5, 0, "R4 clear tx service");
    doEv(3, 0, "R6 read with tx pending");
    doEv(4, 0, "R5 clear tx A");
    doEv(1, 1, "R2 rx B");
    doEv(4, 1, "R5 clear tx re-raises rx B");
    doEv(3, 1, "R6 read B");
    doEv(6, 0, "R12 code 6");
    doEv(7, 1, "R12 code 7");

    // break source alone
    txIntEn = 2'b00; rxIntMode = 4'b0000; brkIntEn = 2'b01; brkStatus = 2'b01;
    idle("R10 break on");
    brkStatus = 2'b00;
    idle("R10 break off");
    brkIntEn = 2'b00;

    // status-high vector codes
    statusHigh = 1'b1;
    doEv(1, 0, "R7 hi rx A");
    doEv(3, 0, "R7 hi none");
    doEv(2, 0, "R7 hi tx A");
    doEv(4, 0, "R7 hi clear");

    // sweep over every configuration with pseudo-random event streams
    lfsr = 16'hACE1;
    for (int hi = 0; hi < 2; hi++) begin
      for (int cfg = 0; cfg < 256; cfg++) begin
        logic [7:0] cf = 8'(cfg);
        statusHigh = 1'(hi);
        txIntEn    = cf[1:0];
        rxIntMode  = cf[5:2];
        brkIntEn   = {1'b0, cf[6]};
        brkStatus  = {cf[7], cf[7]};
        for (int k = 0; k < 8; k++) begin
          int kind;
          lfsr = lfsr[0] ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
          kind = int'(lfsr[2:0]);
          case (kind)
            1: doEv(kind, int'(lfsr[3]), "R2 sweep");
            2: doEv(kind, int'(lfsr[3]), "R3 sweep");
            3: doEv(kind, int'(lfsr[3]), "R6 sweep");
            4: doEv(kind, int'(lfsr[3]), "R5 sweep");
            5: doEv(kind, int'(lfsr[3]), "R4 sweep");
            default: doEv(kind, int'(lfsr[3]), "R12 sweep");
          endcase
        end
      end
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule